// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 32 level interrupt inputs into one request line for a processor. Each input sets a sticky capture bit that stays set until software acknowledges it. A per-input enable mask selects which captured bits count as pending. Software never writes the mask directly. It changes the mask only through a set strobe and a clear strobe, so that two agents can change different bits without a read-modify-write.

Software reaches the block through a plain word-indexed register port: a 3-bit index, a write strobe, write data, and combinational read data. A master register holds a global gate bit and a one-shot mode bit. The mode bit is handled by a two-state machine: `HW_OPEN` moves to `HW_LOCKED` when a write to the master register has bit 1 set. `HW_LOCKED` has no exit except reset. Among the pending inputs the lowest index wins. Its number is readable from a vector register.

Top module: `intc_top`

## Requirements
- R1: Register indices are: capture 0, pending 1, mask 2, acknowledge 3, mask-set 4, mask-clear 5, vector 6, master 7. Indices 3, 4 and 5 always read as zero.
- R2: A capture bit becomes 1 on the clock edge at which its input is high. It stays 1 after the input returns low.
- R3: A write to index 3 clears every capture bit whose write-data bit is 1. If that input is high on the same edge, the capture bit stays 1.
- R4: A write to index 4 sets every mask bit whose write-data bit is 1.
- R5: A write to index 5 clears every mask bit whose write-data bit is 1. Zero bits in a write to index 4 or 5 leave the mask unchanged.
- R6: Index 1 reads the capture bits AND the mask bits.
- R7: Index 6 reads the lowest set bit position of the pending word, zero-extended. When nothing is pending it reads all ones.
- R8: `irq_o` is a register. After each edge it equals the gate bit AND (pending word not zero), as both stood before that edge.
- R9: While the gate bit (master bit 0) is 0, `irq_o` is 0 from the next edge on.
- R10: The mode bit (master bit 1) resets to 0. A write with bit 1 set makes it 1, and after that it stays 1 until reset. Master bits above bit 1 read as zero.
- R11: Reset clears the capture bits, the mask, the master register and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Level interrupt inputs |
| addr | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the indexed register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: 32 inputs and a 32-bit data word. With these values the top input, index 31, can be driven and the all-ones "nothing pending" vector can be observed. The bench walks the winner from index 0 through index 1 to index 31 by acknowledging lower bits. It also pins down the one-cycle lag of the request output after the gate is opened.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CAPTURE = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PENDING = 3'd1;
    localparam logic [ADDR_W-1:0] REG_MASK    = 3'd2;
    localparam logic [ADDR_W-1:0] REG_ACK     = 3'd3;
    localparam logic [ADDR_W-1:0] REG_MSET    = 3'd4;
    localparam logic [ADDR_W-1:0] REG_MCLR    = 3'd5;
    localparam logic [ADDR_W-1:0] REG_VECTOR  = 3'd6;
    localparam logic [ADDR_W-1:0] REG_MASTER  = 3'd7;

    typedef enum logic {
        HW_OPEN   = 1'b0,
        HW_LOCKED = 1'b1
    } mode_state_e;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int unsigned N_IRQ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             ack_we,
    input  logic [N_IRQ-1:0] ack_bits,
    output logic [N_IRQ-1:0] capture_o
);
    logic [N_IRQ-1:0] cap_q;
    logic [N_IRQ-1:0] drop;

    always_comb begin
        drop = ack_we ? ack_bits : '0;
    end

    // a live input overrides an acknowledge on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= (cap_q & ~drop) | irq_in;
        end
    end

    assign capture_o = cap_q;
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
    parameter int unsigned N_IRQ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [N_IRQ-1:0] bits,
    output logic [N_IRQ-1:0] mask_o
);
    logic [N_IRQ-1:0] mask_q;
    logic [N_IRQ-1:0] raise;
    logic [N_IRQ-1:0] lower;

    always_comb begin
        raise = set_we ? bits : '0;
        lower = clr_we ? bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | raise) & ~lower;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int unsigned N_IRQ = 32,
    localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0] pend,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N_IRQ-1:0] first;

    // one-hot winner: a bit wins when no lower bit is pending
    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_win
            if (g == 0) begin : g_lsb
                assign first[g] = pend[g];
            end else begin : g_upper
                assign first[g] = pend[g] & ~(|pend[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (first[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
        any_o = |pend;
    end
endmodule

// File: rtl/intc_master.sv
module intc_master
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_we,
    input  logic [1:0] wr_bits,
    output logic       gate_o,
    output logic       mode_o
);
    mode_state_e state_q;
    mode_state_e state_d;
    logic        gate_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HW_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HW_OPEN: begin
                if (wr_we && wr_bits[1]) begin
                    state_d = HW_LOCKED;
                end
            end
            HW_LOCKED: begin
                state_d = HW_LOCKED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (wr_we) begin
            gate_q <= wr_bits[0];
        end
    end

    // outputs
    always_comb begin
        gate_o = gate_q;
        mode_o = 1'b0;
        unique case (state_q)
            HW_OPEN:   mode_o = 1'b0;
            HW_LOCKED: mode_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic [N_IRQ-1:0] capture_q;
    logic [N_IRQ-1:0] mask_q;
    logic [N_IRQ-1:0] pend;
    logic             gate_q;
    logic             mode_q;
    logic             any_pend;
    logic [IDX_W-1:0] win_idx;
    logic             irq_q;

    logic ack_we;
    logic set_we;
    logic clr_we;
    logic mst_we;

    always_comb begin
        ack_we = wr_en && (addr == REG_ACK);
        set_we = wr_en && (addr == REG_MSET);
        clr_we = wr_en && (addr == REG_MCLR);
        mst_we = wr_en && (addr == REG_MASTER);
    end

    intc_capture #(.N_IRQ(N_IRQ)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .ack_we    (ack_we),
        .ack_bits  (wr_data[N_IRQ-1:0]),
        .capture_o (capture_q)
    );

    intc_mask #(.N_IRQ(N_IRQ)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .bits   (wr_data[N_IRQ-1:0]),
        .mask_o (mask_q)
    );

    intc_master u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_we   (mst_we),
        .wr_bits (wr_data[1:0]),
        .gate_o  (gate_q),
        .mode_o  (mode_q)
    );

    assign pend = capture_q & mask_q;

    intc_prio #(.N_IRQ(N_IRQ)) u_prio (
        .pend  (pend),
        .any_o (any_pend),
        .idx_o (win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= gate_q & any_pend;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            REG_CAPTURE: rd_data = DATA_W'(capture_q);
            REG_PENDING: rd_data = DATA_W'(pend);
            REG_MASK:    rd_data = DATA_W'(mask_q);
            REG_ACK:     rd_data = '0;
            REG_MSET:    rd_data = '0;
            REG_MCLR:    rd_data = '0;
            REG_VECTOR:  rd_data = any_pend ? DATA_W'(win_idx) : '1;
            REG_MASTER:  rd_data = DATA_W'({mode_q, gate_q});
        endcase
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_IRQ-1:0]  irq_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_o,
    input logic [N_IRQ-1:0]  capture,
    input logic [N_IRQ-1:0]  mask,
    input logic              gate,
    input logic              mode
);
    // R2
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((capture & $past(irq_in)) == $past(irq_in)));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ACK)
        |=> ((capture & $past(wr_data[N_IRQ-1:0]) & ~$past(irq_in)) == '0));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_MSET)
        |=> ((mask & $past(wr_data[N_IRQ-1:0])) == $past(wr_data[N_IRQ-1:0])));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_MCLR) |=> ((mask & $past(wr_data[N_IRQ-1:0])) == '0));

    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !irq_o);

    // R10
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> mode);

    // R7
    vector_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_VECTOR && (capture & mask) == '0) |-> (rd_data == '1));
endmodule

bind intc_top intc_chk #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .capture (capture_q),
    .mask    (mask_q),
    .gate    (gate_q),
    .mode    (mode_q)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
    import intc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ  = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_IRQ-1:0]  irq_in = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    bit                kind_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_top #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    // driver tasks
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drive_irq(input logic [N_IRQ-1:0] v);
        @(negedge clk); #1;
        irq_in = v;
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                          input string t);
        @(negedge clk); #1;
        addr = a; wr_en = 1'b0;
        exp_q.push_back(e); tag_q.push_back(t); kind_q.push_back(1'b0);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk); #1;
        exp_q.push_back(DATA_W'(e)); tag_q.push_back(t); kind_q.push_back(1'b1);
    endtask

    // monitor: compares queued expectations with the outputs
    initial begin
        forever begin
            @(negedge clk); #3;
            while (exp_q.size() > 0) begin
                logic [DATA_W-1:0] e;
                logic [DATA_W-1:0] act;
                string t;
                bit k;
                e = exp_q.pop_front(); t = tag_q.pop_front(); k = kind_q.pop_front();
                act = k ? DATA_W'(irq_o) : rd_data;
                n_chk++;
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s: %s actual=%h expected=%h", t,
                             k ? "irq_o" : "rd_data", act, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        chk_rd(REG_CAPTURE, '0, "R11");
        chk_rd(REG_MASK, '0, "R11");
        chk_rd(REG_MASTER, '0, "R11");
        chk_irq(1'b0, "R11");
        chk_rd(REG_VECTOR, '1, "R7");

        // R2 capture and hold
        drive_irq(32'h0000_0110);
        drive_irq('0);
        chk_rd(REG_CAPTURE, 32'h0000_0110, "R2");
        chk_rd(REG_CAPTURE, 32'h0000_0110, "R2");
        chk_rd(REG_PENDING, '0, "R6");

        // R4 set strobe
        wr(REG_MSET, 32'h0000_0100);
        chk_rd(REG_MASK, 32'h0000_0100, "R4");
        chk_rd(REG_MSET, '0, "R1");
        chk_rd(REG_PENDING, 32'h0000_0100, "R6");
        chk_rd(REG_VECTOR, 32'd8, "R7");
        wr(REG_MSET, 32'h0000_0010);
        chk_rd(REG_VECTOR, 32'd4, "R7");
        wr(REG_MSET, '0);
        chk_rd(REG_MASK, 32'h0000_0110, "R5");

        // R9 gate closed, R8 one-cycle lag after opening
        chk_irq(1'b0, "R9");
        wr(REG_MASTER, 32'h1);
        chk_irq(1'b0, "R8");
        chk_irq(1'b1, "R8");

        // R5 clear strobe
        wr(REG_MCLR, 32'h0000_0010);
        chk_rd(REG_MASK, 32'h0000_0100, "R5");
        chk_rd(REG_VECTOR, 32'd8, "R7");
        chk_rd(REG_MCLR, '0, "R1");

        // R3 acknowledge
        wr(REG_ACK, 32'h0000_0100);
        chk_rd(REG_CAPTURE, 32'h0000_0010, "R3");
        chk_rd(REG_PENDING, '0, "R6");
        chk_irq(1'b0, "R8");
        chk_rd(REG_ACK, '0, "R1");

        // R3 input wins over acknowledge
        drive_irq(32'h8000_0000);
        wr(REG_ACK, 32'h8000_0000);
        chk_rd(REG_CAPTURE, 32'h8000_0010, "R3");
        drive_irq('0);
        wr(REG_ACK, 32'h8000_0000);
        chk_rd(REG_CAPTURE, 32'h0000_0010, "R3");

        // R10 mode lock
        wr(REG_MASTER, 32'h3);
        chk_rd(REG_MASTER, 32'h3, "R10");
        wr(REG_MASTER, 32'h1);
        chk_rd(REG_MASTER, 32'h3, "R10");
        wr(REG_MASTER, 32'h0);
        chk_rd(REG_MASTER, 32'h2, "R10");
        wr(REG_MASTER, 32'hFFFF_FFFC);
        chk_rd(REG_MASTER, 32'h2, "R10");
        wr(REG_MSET, 32'hFFFF_FFFF);
        @(negedge clk);
        chk_irq(1'b0, "R9");

        // R7 priority walk
        wr(REG_MASTER, 32'h1);
        drive_irq(32'hFFFF_FFFF);
        drive_irq('0);
        chk_rd(REG_VECTOR, 32'd0, "R7");
        wr(REG_ACK, 32'h0000_0001);
        chk_rd(REG_VECTOR, 32'd1, "R7");
        wr(REG_ACK, 32'h7FFF_FFFF);
        chk_rd(REG_VECTOR, 32'd31, "R7");
        chk_rd(REG_PENDING, 32'h8000_0000, "R6");
        chk_irq(1'b1, "R8");

        // R11 and R10 after a second reset
        @(negedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk_rd(REG_MASTER, '0, "R10");
        chk_rd(REG_CAPTURE, '0, "R11");
        chk_rd(REG_MASK, '0, "R11");
        chk_irq(1'b0, "R11");

        repeat (2) @(negedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule